// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block sits between a host register bus and an external eight-input, 12-bit analog-to-digital converter core. The host programs a small register set to start a one-shot conversion on a chosen input, or to run periodic scans over a set of inputs. The block issues one conversion request at a time to the converter core and collects each result. It can optionally merge four back-to-back samples into one averaged value. Each result is stored in its own per-channel register pair.

When a single conversion or a whole scan completes, the block sets an end-of-conversion status flag. If that flag is enabled, the interrupt output rises. The host clears the flag by writing zero to it. Results are split into a high byte and a low nibble so that an 8-bit bus can fetch them. The bus is a plain synchronous port: address, write data, write enable, and combinational read data.

Register map: control at 0x00, scan period at 0x01, scan channel mask at 0x02, end-of-conversion status at 0x03, interrupt enable at 0x04, and result pairs from 0x10. Control fields are: bits [2:0] channel, bit 3 average, bit 4 start, bit 5 auto-scan.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control bits [2:0] choose the input for a one-shot conversion. The channel output presents that index, and it stays constant while the request is outstanding.
- R2: With control bit 3 set, each conversion takes four samples of the channel. The samples are summed in a 14-bit accumulator, and the stored value is the sum shifted right by two, with truncation.
- R3: Writing control bit 4 as 1 while idle starts a one-shot conversion. Bit 4 reads 1 until the result is stored, then clears by itself.
- R4: With control bit 5 set, a scan starts every (period + 1) clock cycles when the block is idle. The scan converts each channel whose bit is set in the mask register, lowest index first.
- R5: Status bit 0 is set when a one-shot conversion or a full scan ends. The interrupt output is high exactly while status bit 0 and enable bit 0 are both 1.
- R6: Writing 0 to status bit 0 clears it, and the interrupt drops in the next cycle, unless a sequence ends in that same cycle.
- R7: Channel n reads its result bits [11:4] at address 0x10+2n. It reads bits [3:0] in the low nibble of address 0x11+2n, and the upper nibble of that byte reads 0.
- R8: A channel's result pair changes only when a result is delivered, and both bytes change in the same cycle.
- R9: Writing 0x00 to the control register ends auto-scan and discards any channels not yet converted. No new request is issued after the one already in flight.
- R10: At most one conversion request is outstanding. A start write while busy is ignored.
- R11: After reset, all registers read 0, and the interrupt and request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write enable, one write per cycle |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | End-of-conversion interrupt |
| conv_start_o | output | 1 | One-cycle conversion request to the converter core |
| conv_ch_o | output | 3 | Input selected for the current request |
| conv_done_i | input | 1 | One-cycle strobe from the core, result valid |
| conv_data_i | input | 12 | Converter result |

## Verification
The bound checker watches several invariants on every cycle:
- only one request is outstanding, and the channel is held while it is;
- the start bit self-clears only together with a raised status flag;
- the interrupt never rises without that flag, and a status clear drops the interrupt;
- result registers stay untouched between deliveries;
- a zero write to control empties the pending scan.

Only the directed scenarios can show the arithmetic and the sequencing. This covers the truncating four-sample average, including a full-scale sum, and the lowest-first order of a scan. It also covers the byte split of stored results, and that a start issued while busy leaves no trace in any result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int unsigned ADR_CTRL   = 'h00;
   localparam int unsigned ADR_PERIOD = 'h01;
   localparam int unsigned ADR_MASK   = 'h02;
   localparam int unsigned ADR_STAT   = 'h03;
   localparam int unsigned ADR_IEN    = 'h04;

   localparam int unsigned BIT_AVG  = 3;
   localparam int unsigned BIT_GO   = 4;
   localparam int unsigned BIT_AUTO = 5;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_REQ  = 2'd1,
      ENG_WAIT = 2'd2
   } eng_state_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                run_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                tick_o
);
   logic [PERIOD_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == period_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (!run_i)  cnt_q <= '0;
      else if (tick_o)  cnt_q <= '0;
      else              cnt_q <= cnt_q + PERIOD_W'(1);
   end
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W  = 3,
   parameter int unsigned RES_W = 12,
   parameter int unsigned AVG_N = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             job_start_i,
   input  logic [CH_W-1:0]  job_ch_i,
   input  logic             job_avg_i,
   output logic             busy_o,
   output logic             conv_start_o,
   output logic [CH_W-1:0]  conv_ch_o,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] conv_data_i,
   output logic             res_valid_o,
   output logic [CH_W-1:0]  res_ch_o,
   output logic [RES_W-1:0] res_data_o
);
   localparam int unsigned AVG_LOG2 = $clog2(AVG_N);
   localparam int unsigned ACC_W    = RES_W + AVG_LOG2;
   localparam int unsigned CNT_W    = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;

   eng_state_e         state_q;
   logic [CH_W-1:0]    ch_q;
   logic               avg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [ACC_W-1:0]   acc_q;
   logic [ACC_W-1:0]   acc_next;
   logic [RES_W-1:0]   avg_val;
   logic               last_sample;

   assign acc_next    = acc_q + ACC_W'(conv_data_i);
   assign last_sample = !avg_q || (cnt_q == CNT_W'(AVG_N - 1));

   generate
      if (AVG_LOG2 == 0) begin : g_no_avg
         assign avg_val = acc_next[RES_W-1:0];
      end else begin : g_avg
         assign avg_val = acc_next[ACC_W-1:AVG_LOG2];
      end
   endgenerate

   assign busy_o       = (state_q != ENG_IDLE);
   assign conv_start_o = (state_q == ENG_REQ);
   assign conv_ch_o    = ch_q;
   assign res_ch_o     = ch_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ENG_IDLE;
         ch_q        <= '0;
         avg_q       <= 1'b0;
         cnt_q       <= '0;
         acc_q       <= '0;
         res_valid_o <= 1'b0;
         res_data_o  <= '0;
      end else begin
         res_valid_o <= 1'b0;
         unique case (state_q)
            ENG_IDLE: if (job_start_i) begin
               ch_q    <= job_ch_i;
               avg_q   <= job_avg_i;
               cnt_q   <= '0;
               acc_q   <= '0;
               state_q <= ENG_REQ;
            end
            ENG_REQ: state_q <= ENG_WAIT;
            ENG_WAIT: if (conv_done_i) begin
               if (last_sample) begin
                  res_data_o  <= avg_q ? avg_val : conv_data_i;
                  res_valid_o <= 1'b1;
                  state_q     <= ENG_IDLE;
               end else begin
                  acc_q   <= acc_next;
                  cnt_q   <= cnt_q + CNT_W'(1);
                  state_q <= ENG_REQ;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned RES_W    = 12,
   parameter int unsigned AVG_N    = 4,
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned RES_BASE = 'h10
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [ADDR_W-1:0]          bus_addr_i,
   input  logic [7:0]                 bus_wdata_i,
   input  logic                       bus_we_i,
   output logic [7:0]                 bus_rdata_o,
   output logic                       irq_o,
   output logic                       conv_start_o,
   output logic [$clog2(NUM_CH)-1:0]  conv_ch_o,
   input  logic                       conv_done_i,
   input  logic [RES_W-1:0]           conv_data_i
);
   localparam int unsigned CH_W = $clog2(NUM_CH);
   localparam int unsigned LO_W = RES_W - 8;

   initial begin
      assert (NUM_CH >= 2 && NUM_CH <= 8 && (1 << CH_W) == NUM_CH)
         else $error("NUM_CH must be a power of two from 2 to 8");
      assert (RES_W >= 9 && RES_W <= 16) else $error("RES_W out of range");
      assert (PERIOD_W >= 1 && PERIOD_W <= 8) else $error("PERIOD_W out of range");
      assert ((1 << $clog2(AVG_N)) == AVG_N) else $error("AVG_N not a power of two");
      assert (RES_BASE + 2 * NUM_CH <= (1 << ADDR_W)) else $error("result window outside address space");
   end

   logic [CH_W-1:0]     ch_q;
   logic                avg_q, go_q, auto_q, eoc_q, ien_q;
   logic [PERIOD_W-1:0] period_q;
   logic [NUM_CH-1:0]   mask_q, todo_q;
   logic [RES_W-1:0]    res_q [NUM_CH];
   logic [NUM_CH*RES_W-1:0] res_flat;

   logic wr_ctrl, wr_period, wr_mask, wr_stat, wr_ien;
   logic busy, tick, start_single, start_scan, job_start, seq_done;
   logic [CH_W-1:0] job_ch;
   logic eng_busy, eng_res_valid;
   logic [CH_W-1:0]  eng_res_ch;
   logic [RES_W-1:0] eng_res_data;

   assign wr_ctrl   = bus_we_i && (bus_addr_i == ADDR_W'(ADR_CTRL));
   assign wr_period = bus_we_i && (bus_addr_i == ADDR_W'(ADR_PERIOD));
   assign wr_mask   = bus_we_i && (bus_addr_i == ADDR_W'(ADR_MASK));
   assign wr_stat   = bus_we_i && (bus_addr_i == ADDR_W'(ADR_STAT));
   assign wr_ien    = bus_we_i && (bus_addr_i == ADDR_W'(ADR_IEN));

   assign busy         = (|todo_q) || eng_busy;
   assign start_single = wr_ctrl && bus_wdata_i[BIT_GO] && !busy;
   assign start_scan   = tick && !busy && !start_single && (|mask_q);
   assign job_start    = (|todo_q) && !eng_busy;
   assign seq_done     = eng_res_valid && (todo_q == '0);
   assign irq_o        = eoc_q && ien_q;

   always_comb begin
      job_ch = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (todo_q[i]) job_ch = CH_W'(i);
      end
   end

   adc_seq_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (auto_q),
      .period_i (period_q),
      .tick_o   (tick)
   );

   adc_seq_engine #(.CH_W(CH_W), .RES_W(RES_W), .AVG_N(AVG_N)) u_engine (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .job_start_i  (job_start),
      .job_ch_i     (job_ch),
      .job_avg_i    (avg_q),
      .busy_o       (eng_busy),
      .conv_start_o (conv_start_o),
      .conv_ch_o    (conv_ch_o),
      .conv_done_i  (conv_done_i),
      .conv_data_i  (conv_data_i),
      .res_valid_o  (eng_res_valid),
      .res_ch_o     (eng_res_ch),
      .res_data_o   (eng_res_data)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ch_q     <= '0;
         avg_q    <= 1'b0;
         go_q     <= 1'b0;
         auto_q   <= 1'b0;
         eoc_q    <= 1'b0;
         ien_q    <= 1'b0;
         period_q <= '0;
         mask_q   <= '0;
         todo_q   <= '0;
      end else begin
         if (job_start)    todo_q <= todo_q & ~(NUM_CH'(1) << job_ch);
         if (start_single) todo_q <= NUM_CH'(1) << bus_wdata_i[CH_W-1:0];
         if (start_scan)   todo_q <= mask_q;
         if (seq_done)     go_q   <= 1'b0;
         if (start_single) go_q   <= 1'b1;
         if (wr_ctrl) begin
            ch_q   <= bus_wdata_i[CH_W-1:0];
            avg_q  <= bus_wdata_i[BIT_AVG];
            auto_q <= bus_wdata_i[BIT_AUTO];
            if (bus_wdata_i == 8'h00) todo_q <= '0;
         end
         if (wr_period) period_q <= bus_wdata_i[PERIOD_W-1:0];
         if (wr_mask)   mask_q   <= bus_wdata_i[NUM_CH-1:0];
         if (wr_ien)    ien_q    <= bus_wdata_i[0];
         if (wr_stat)   eoc_q    <= eoc_q & bus_wdata_i[0];
         if (seq_done)  eoc_q    <= 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_res
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               res_q[g] <= '0;
            else if (eng_res_valid && (eng_res_ch == CH_W'(g)))
               res_q[g] <= eng_res_data;
         end
         assign res_flat[g*RES_W +: RES_W] = res_q[g];
      end
   endgenerate

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(ADR_CTRL)) begin
         bus_rdata_o[CH_W-1:0] = ch_q;
         bus_rdata_o[BIT_AVG]  = avg_q;
         bus_rdata_o[BIT_GO]   = go_q;
         bus_rdata_o[BIT_AUTO] = auto_q;
      end
      if (bus_addr_i == ADDR_W'(ADR_PERIOD)) bus_rdata_o = 8'(period_q);
      if (bus_addr_i == ADDR_W'(ADR_MASK))   bus_rdata_o = 8'(mask_q);
      if (bus_addr_i == ADDR_W'(ADR_STAT))   bus_rdata_o = {7'd0, eoc_q};
      if (bus_addr_i == ADDR_W'(ADR_IEN))    bus_rdata_o = {7'd0, ien_q};
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr_i == ADDR_W'(RES_BASE + 2 * i))
            bus_rdata_o = res_q[i][RES_W-1 -: 8];
         if (bus_addr_i == ADDR_W'(RES_BASE + 2 * i + 1))
            bus_rdata_o = 8'(res_q[i][LO_W-1:0]);
      end
   end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned RES_W  = 12,
   parameter int unsigned ADDR_W = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [7:0]                bus_wdata,
   input logic                      bus_we,
   input logic                      irq,
   input logic                      conv_start,
   input logic [$clog2(NUM_CH)-1:0] conv_ch,
   input logic                      conv_done,
   input logic                      go,
   input logic                      eoc,
   input logic                      auto_on,
   input logic [NUM_CH-1:0]         todo,
   input logic                      res_valid,
   input logic [NUM_CH*RES_W-1:0]   res_flat
);
   logic out_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          out_q <= 1'b0;
      else if (conv_start) out_q <= 1'b1;
      else if (conv_done)  out_q <= 1'b0;
   end

   logic wr_ctrl, wr_stat;
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
   assign wr_stat = bus_we && (bus_addr == ADDR_W'(ADR_STAT));

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !out_q);                                   // R10
   AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> $stable(conv_ch));                              // R1
   AST_GO_CLEARS_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(go) |-> eoc);                                       // R3
   AST_IRQ_NEEDS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> eoc);                                             // R5
   AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !bus_wdata[0] && !res_valid) |=> !irq);       // R6
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> $stable(res_flat));                        // R8
   AST_STOP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata == 8'h00) |=> (!auto_on && todo == '0)); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .RES_W  (RES_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk_i),
   .rst_n      (rst_ni),
   .bus_addr   (bus_addr_i),
   .bus_wdata  (bus_wdata_i),
   .bus_we     (bus_we_i),
   .irq        (irq_o),
   .conv_start (conv_start_o),
   .conv_ch    (conv_ch_o),
   .conv_done  (conv_done_i),
   .go         (go_q),
   .eoc        (eoc_q),
   .auto_on    (auto_q),
   .todo       (todo_q),
   .res_valid  (eng_res_valid),
   .res_flat   (res_flat)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        we = 1'b0;
   logic [7:0]  rdata;
   logic        irq, conv_start, conv_done;
   logic [2:0]  conv_ch;
   logic [11:0] conv_data;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   // converter model controls
   int mdl_lat = 3, mdl_base = 0, mdl_chmul = 0, mdl_step = 0, mdl_k = 0;
   int starts = 0;
   int ord [32];
   int ord_n = 0;

   always #2.5 clk = ~clk;

   adc_seq_ctrl dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_we_i (we),
      .bus_rdata_o (rdata), .irq_o (irq),
      .conv_start_o (conv_start), .conv_ch_o (conv_ch),
      .conv_done_i (conv_done), .conv_data_i (conv_data)
   );

   initial begin
      int wait_n;
      int cur_ch;
      wait_n = 0;
      cur_ch = 0;
      conv_done = 1'b0;
      conv_data = '0;
      forever begin
         @(posedge clk);
         conv_done <= 1'b0;
         if (wait_n > 0) begin
            wait_n--;
            if (wait_n == 0) begin
               conv_done <= 1'b1;
               conv_data <= 12'(mdl_base + cur_ch * mdl_chmul + mdl_k * mdl_step);
               mdl_k++;
            end
         end
         if (conv_start) begin
            cur_ch = int'(conv_ch);
            wait_n = mdl_lat;
            if (ord_n < 32) ord[ord_n] = cur_ch;
            ord_n++;
            starts++;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      addr = 8'(a); wdata = 8'(d); we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      @(negedge clk);
      addr = 8'(a);
      #1 d = int'(rdata);
   endtask

   task automatic wait_go_clear();
      int v;
      for (int i = 0; i < 3000; i++) begin
         rd(0, v);
         if (v[4] == 1'b0) break;
      end
   endtask

   task automatic wait_eoc();
      int v;
      for (int i = 0; i < 3000; i++) begin
         rd(3, v);
         if (v[0]) break;
      end
   endtask

   task automatic set_model(int lat, int base, int chmul, int step);
      mdl_lat = lat; mdl_base = base; mdl_chmul = chmul; mdl_step = step;
      mdl_k = 0; starts = 0; ord_n = 0;
   endtask

   task automatic t_reset();
      int v;
      rd(0, v);  chk("R11 ctrl after reset", v, 0);
      rd(3, v);  chk("R11 status after reset", v, 0);
      rd('h10, v); chk("R11 result after reset", v, 0);
      chk("R11 irq after reset", int'(irq), 0);
      chk("R11 conv_start after reset", int'(conv_start), 0);
   endtask

   task automatic t_single();
      int v;
      set_model(3, 'hABC, 0, 0);
      wr(0, 'h11);
      rd(0, v); chk("R3 go reads 1 while busy", int'(v[4]), 1);
      wait_go_clear();
      rd(0, v);  chk("R3 go self-cleared", v, 'h01);
      chk("R1 requested channel", ord[0], 1);
      rd('h12, v); chk("R7 ch1 high byte", v, 'hAB);
      rd('h13, v); chk("R7 ch1 low nibble, upper zero", v, 'h0C);
      rd(3, v);  chk("R5 eoc set", v, 1);
      chk("R5 irq low while disabled", int'(irq), 0);
      wr(4, 1);
      #1 chk("R5 irq high when enabled", int'(irq), 1);
   endtask

   task automatic t_clear();
      int v;
      wr(3, 0);
      #1 chk("R6 irq dropped after clear", int'(irq), 0);
      rd(3, v); chk("R6 eoc cleared", v, 0);
   endtask

   task automatic t_avg();
      int v;
      set_model(2, 100, 0, 1);
      wr(0, 'h1B);
      wait_go_clear();
      chk("R2 four samples taken", starts, 4);
      rd('h16, v); chk("R2 avg high byte (406>>2=101)", v, 'h06);
      rd('h17, v); chk("R2 avg low nibble", v, 'h05);
      set_model(2, 4095, 0, 0);
      wr(0, 'h1C);
      wait_go_clear();
      rd('h18, v); chk("R2 full-scale avg high", v, 'hFF);
      rd('h19, v); chk("R2 full-scale avg low", v, 'h0F);
      wr(3, 0);
   endtask

   task automatic t_busy();
      int v;
      set_model(30, 'h321, 0, 0);
      wr(0, 'h12);
      repeat (5) @(negedge clk);
      wr(0, 'h16);
      wait_go_clear();
      chk("R10 second start ignored", starts, 1);
      rd('h1C, v); chk("R10 ch6 untouched", v, 0);
      rd('h14, v); chk("R10 ch2 converted", v, 'h32);
      wr(3, 0);
   endtask

   task automatic t_scan();
      int v;
      int snap;
      set_model(2, 'h100, 'h11, 0);
      wr(1, 20);
      wr(2, 'hA5);
      wr(0, 'h20);
      wait_eoc();
      wr(0, 0);
      chk("R4 scan order #0", ord[0], 0);
      chk("R4 scan order #1", ord[1], 2);
      chk("R4 scan order #2", ord[2], 5);
      chk("R4 scan order #3", ord[3], 7);
      rd('h1A, v); chk("R4 ch5 high", v, 'h15);
      rd('h1B, v); chk("R7 ch5 low", v, 'h05);
      rd('h1E, v); chk("R4 ch7 high", v, 'h17);
      chk("R5 irq after scan", int'(irq), 1);
      repeat (50) @(negedge clk);
      snap = starts;
      repeat (300) @(negedge clk);
      chk("R9 no requests after stop", starts, snap);
      rd(0, v); chk("R9 auto bit cleared", int'(v[5]), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_clear();
      t_avg();
      t_busy();
      t_scan();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule